// File: doc/BRIEF.md
# Two-Level Address Translation Buffer with Hardware Refill

This block translates virtual page numbers into physical page numbers through two fully associative translation arrays. A small instruction array (4 entries by default) serves instruction fetches. A larger unified array (16 entries by default) serves data lookups and also acts as the backing store for the instruction array. An instruction lookup that misses the small array costs one extra cycle. During that cycle the unified array is searched, and a matching entry is copied into the instruction slot named by a pairwise-age LRU matrix.

Software manages both arrays in two ways. It fills three staging inputs and pulses a load-entry command, which writes the unified entry pointed to by a replace counter. It also has a memory-mapped port that reads, writes or invalidates any entry of either array. The load-entry command never changes the instruction array, so a translation that has been purged from the unified array can keep hitting in the instruction array until software invalidates it. A lookup that finds no usable translation raises a miss fault. A lookup that finds more than one usable translation raises a multiple-hit fault. Every successful translation returns the cacheable, write-through, space and timing attribute bits together with the physical page.

Top module: `xlat_twolevel`

## Requirements
- R1: A pulse on `ld_en` writes the unified entry indexed by the replace counter. The fields are taken as follows: `stg_hi` = {vpn[29:8], asid[7:0]}, `stg_lo` = {valid[22], shared[21], ppn[20:2], cacheable[1], write-through[0]}, `stg_as` = {space[3:1], timing[0]}.
- R2: The load-entry command never alters the instruction array. An instruction entry whose unified copy has been overwritten still returns its old translation.
- R3: An instruction lookup that hits the instruction array presents its result on `i_valid` one cycle after `i_req`. It leaves `i_ready` high.
- R4: An instruction lookup that misses the instruction array drops `i_ready` for exactly one cycle and presents its result two cycles after `i_req`. On a unified hit, the matching entry is copied into the LRU victim slot.
- R5: The LRU field is 6 bits. Bits 0 to 5 cover the slot pairs (0,1), (0,2), (0,3), (1,2), (1,3), (2,3), and a 1 means that the lower slot of the pair was used more recently. The victim is the lowest slot that is older than every other slot, or slot 0 when no slot qualifies. A hit or a refill makes the slot the newest.
- R6: A lookup with no usable entry raises the miss fault and returns a zero page and zero attributes. This applies to instruction lookups after the refill search and to data lookups.
- R7: More than one usable match in the array being searched raises the multiple-hit fault instead of returning a translation.
- R8: A data lookup on `d_req` searches only the unified array. It presents its result on `d_valid` one cycle later. The attribute bits are {cacheable[5], write-through[4], space[3:1], timing[0]}.
- R9: The memory-mapped port uses the entry layout {valid[56], shared[55], vpn[54:33], asid[32:25], ppn[24:6], attr[5:0]}. `mm_sel_u`=1 selects the unified array. `mm_rdata` shows the addressed entry in the same cycle. `mm_we` writes the whole entry. `mm_inval` clears only the valid bit. A port write wins over any hardware write to the same array in the same cycle.
- R10: An entry is usable only when it is valid, its vpn equals the lookup vpn, and either its shared bit is set or its asid equals `cur_asid`.
- R11: After reset every entry is invalid, the replace counter and LRU field are zero, no result strobe is high and `i_ready` is high.
- R12: The replace counter advances by one per cycle in which the unified array is accessed (load-entry, data lookup or refill search), wrapping from 15 to 0. A `ctl_we` write loads {lru[9:4], counter[3:0]} and takes priority over any hardware update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_asid | input | 8 | Current address-space identifier |
| i_req | input | 1 | Instruction lookup request (only while `i_ready`) |
| i_vpn | input | 22 | Instruction virtual page number |
| i_ready | output | 1 | Instruction path idle, can accept a request |
| i_valid | output | 1 | Instruction result strobe |
| i_ppn | output | 19 | Instruction physical page number |
| i_attr | output | 6 | Instruction attribute bits |
| i_miss | output | 1 | Instruction miss fault |
| i_multi | output | 1 | Instruction multiple-hit fault |
| d_req | input | 1 | Data lookup request |
| d_vpn | input | 22 | Data virtual page number |
| d_valid | output | 1 | Data result strobe |
| d_ppn | output | 19 | Data physical page number |
| d_attr | output | 6 | Data attribute bits |
| d_miss | output | 1 | Data miss fault |
| d_multi | output | 1 | Data multiple-hit fault |
| ld_en | input | 1 | Load-entry command |
| stg_hi | input | 30 | Staging: page number and address-space ID |
| stg_lo | input | 23 | Staging: valid, shared, physical page, cache bits |
| stg_as | input | 4 | Staging: space and timing bits |
| ctl_we | input | 1 | Control register write |
| ctl_wdata | input | 10 | Control write value {lru, counter} |
| ctl_rdata | output | 10 | Control register value {lru, counter} |
| mm_sel_u | input | 1 | Port array select: 1 unified, 0 instruction |
| mm_idx | input | 4 | Port entry index |
| mm_we | input | 1 | Port entry write |
| mm_inval | input | 1 | Port entry invalidate |
| mm_wdata | input | 57 | Port write entry |
| mm_rdata | output | 57 | Port read entry |

## Verification
On every cycle the assertions check four things. A refill always finishes in exactly one stall cycle. A result never carries both faults at once. The replace counter moves by exactly one step after each unified access. The instruction array stays unchanged unless a refill or a port operation aimed at it is under way. The scenarios are the only way to show that the values are right: the LRU victim order over a sequence of refills and hits, a stale instruction translation surviving a purge, the address-space and shared-page rule, the multiple-hit cases in each array, and the counter wrapping at the top entry.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VPN_W  = 22;
  localparam int ASID_W = 8;
  localparam int PPN_W  = 19;
  localparam int SPC_W  = 3;

  typedef struct packed {
    logic             cache;
    logic             wthru;
    logic [SPC_W-1:0] space;
    logic             timing;
  } attr_t;

  localparam int ATTR_W = $bits(attr_t);

  typedef struct packed {
    logic              valid;
    logic              shared;
    logic [VPN_W-1:0]  vpn;
    logic [ASID_W-1:0] asid;
    logic [PPN_W-1:0]  ppn;
    attr_t             attr;
  } entry_t;

  localparam int ENT_W = $bits(entry_t);
  localparam int XL_W  = PPN_W + ATTR_W;

  typedef enum logic {IP_IDLE, IP_FILL} ipath_t;
endpackage

// File: rtl/tlb_match.sv
module tlb_match
  import tlb_pkg::*;
#(
  parameter int N = 4
) (
  input  entry_t            ents [N],
  input  logic [VPN_W-1:0]  vpn,
  input  logic [ASID_W-1:0] asid,
  output logic [N-1:0]      sel,
  output logic              multi,
  output logic [XL_W-1:0]   xl
);
  for (genvar k = 0; k < N; k++) begin : g_cmp
    assign sel[k] = ents[k].valid && (ents[k].vpn == vpn) &&
                    (ents[k].shared || (ents[k].asid == asid));
  end

  assign multi = ($countones(sel) > 1);

  always_comb begin
    xl = '0;
    for (int k = 0; k < N; k++) begin
      if (sel[k]) xl = xl | {ents[k].ppn, ents[k].attr};
    end
  end
endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
  parameter  int N  = 4,
  localparam int LW = N * (N - 1) / 2
) (
  input  logic [LW-1:0] cur,
  input  logic [N-1:0]  touch,
  output logic [LW-1:0] nxt,
  output logic [N-1:0]  victim
);
  // position of pair (a,b) with a < b
  function automatic int pidx(int a, int b);
    return a * (2 * N - a - 1) / 2 + (b - a - 1);
  endfunction

  always_comb begin
    nxt = cur;
    for (int k = 0; k < N; k++) begin
      if (touch[k]) begin
        for (int j = 0; j < N; j++) begin
          if (j < k) nxt[pidx(j, k)] = 1'b0;
          else if (j > k) nxt[pidx(k, j)] = 1'b1;
        end
      end
    end
  end

  logic [N-1:0] oldest;

  always_comb begin
    for (int k = 0; k < N; k++) begin
      oldest[k] = 1'b1;
      for (int j = 0; j < N; j++) begin
        if (j < k) oldest[k] = oldest[k] & cur[pidx(j, k)];
        else if (j > k) oldest[k] = oldest[k] & ~cur[pidx(k, j)];
      end
    end
  end

  always_comb begin
    victim    = '0;
    victim[0] = 1'b1;
    for (int k = N - 1; k >= 0; k--) begin
      if (oldest[k]) begin
        victim    = '0;
        victim[k] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/xlat_twolevel.sv
module xlat_twolevel
  import tlb_pkg::*;
#(
  parameter  int I_N  = 4,
  parameter  int U_N  = 16,
  localparam int IW   = $clog2(I_N),
  localparam int UW   = $clog2(U_N),
  localparam int LW   = I_N * (I_N - 1) / 2,
  localparam int CW   = LW + UW,
  localparam int HI_W = VPN_W + ASID_W,
  localparam int LO_W = PPN_W + 4,
  localparam int AS_W = SPC_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ASID_W-1:0] cur_asid,
  input  logic              i_req,
  input  logic [VPN_W-1:0]  i_vpn,
  output logic              i_ready,
  output logic              i_valid,
  output logic [PPN_W-1:0]  i_ppn,
  output logic [ATTR_W-1:0] i_attr,
  output logic              i_miss,
  output logic              i_multi,
  input  logic              d_req,
  input  logic [VPN_W-1:0]  d_vpn,
  output logic              d_valid,
  output logic [PPN_W-1:0]  d_ppn,
  output logic [ATTR_W-1:0] d_attr,
  output logic              d_miss,
  output logic              d_multi,
  input  logic              ld_en,
  input  logic [HI_W-1:0]   stg_hi,
  input  logic [LO_W-1:0]   stg_lo,
  input  logic [AS_W-1:0]   stg_as,
  input  logic              ctl_we,
  input  logic [CW-1:0]     ctl_wdata,
  output logic [CW-1:0]     ctl_rdata,
  input  logic              mm_sel_u,
  input  logic [UW-1:0]     mm_idx,
  input  logic              mm_we,
  input  logic              mm_inval,
  input  logic [ENT_W-1:0]  mm_wdata,
  output logic [ENT_W-1:0]  mm_rdata
);
  entry_t itlb_q [I_N];
  entry_t itlb_d [I_N];
  entry_t utlb_q [U_N];
  entry_t utlb_d [U_N];

  logic [UW-1:0]    urc_q, urc_d;
  logic [LW-1:0]    lru_q, lru_d, lru_nxt;
  logic [I_N-1:0]   touch, victim;
  ipath_t           st_q, st_d;
  logic [VPN_W-1:0] fvpn_q;
  logic             fvpn_en;
  logic             uacc;

  logic              iv_d, imiss_d, imul_d;
  logic [XL_W-1:0]   ixl_d;
  logic [XL_W-1:0]   ixl_q, dxl_q;

  // ---------------- searches
  logic [I_N-1:0]  im;
  logic            imul;
  logic [XL_W-1:0] ixl;
  logic [U_N-1:0]  fm, dm;
  logic            fmul, dmul;
  logic [XL_W-1:0] fxl, dxl;
  entry_t          fent;

  tlb_match #(.N(I_N)) u_isrch (
    .ents(itlb_q), .vpn(i_vpn), .asid(cur_asid),
    .sel(im), .multi(imul), .xl(ixl)
  );

  tlb_match #(.N(U_N)) u_fsrch (
    .ents(utlb_q), .vpn(fvpn_q), .asid(cur_asid),
    .sel(fm), .multi(fmul), .xl(fxl)
  );

  tlb_match #(.N(U_N)) u_dsrch (
    .ents(utlb_q), .vpn(d_vpn), .asid(cur_asid),
    .sel(dm), .multi(dmul), .xl(dxl)
  );

  tlb_lru #(.N(I_N)) u_lru (
    .cur(lru_q), .touch(touch), .nxt(lru_nxt), .victim(victim)
  );

  // full unified entry picked by the refill search
  always_comb begin
    fent = '0;
    for (int k = 0; k < U_N; k++) begin
      if (fm[k]) fent = fent | utlb_q[k];
    end
  end

  // staging registers assembled into one entry
  entry_t stg;
  always_comb begin
    stg.valid       = stg_lo[LO_W-1];
    stg.shared      = stg_lo[LO_W-2];
    stg.vpn         = stg_hi[HI_W-1:ASID_W];
    stg.asid        = stg_hi[ASID_W-1:0];
    stg.ppn         = stg_lo[PPN_W+1:2];
    stg.attr.cache  = stg_lo[1];
    stg.attr.wthru  = stg_lo[0];
    stg.attr.space  = stg_as[AS_W-1:1];
    stg.attr.timing = stg_as[0];
  end

  // ---------------- next state
  always_comb begin
    st_d    = st_q;
    fvpn_en = 1'b0;
    iv_d    = 1'b0;
    imiss_d = 1'b0;
    imul_d  = 1'b0;
    ixl_d   = '0;
    touch   = '0;
    itlb_d  = itlb_q;
    utlb_d  = utlb_q;
    uacc    = ld_en | d_req;

    unique case (st_q)
      IP_IDLE: begin
        if (i_req) begin
          if (imul) begin
            iv_d   = 1'b1;
            imul_d = 1'b1;
          end else if (|im) begin
            iv_d  = 1'b1;
            ixl_d = ixl;
            touch = im;
          end else begin
            st_d    = IP_FILL;
            fvpn_en = 1'b1;
          end
        end
      end
      IP_FILL: begin
        st_d = IP_IDLE;
        iv_d = 1'b1;
        uacc = 1'b1;
        if (fmul) begin
          imul_d = 1'b1;
        end else if (!(|fm)) begin
          imiss_d = 1'b1;
        end else begin
          ixl_d = fxl;
          touch = victim;
          for (int k = 0; k < I_N; k++) begin
            if (victim[k]) itlb_d[k] = fent;
          end
        end
      end
      default: st_d = IP_IDLE;
    endcase

    if (ld_en) utlb_d[urc_q] = stg;

    if (mm_we) begin
      if (mm_sel_u) utlb_d[mm_idx] = entry_t'(mm_wdata);
      else          itlb_d[mm_idx[IW-1:0]] = entry_t'(mm_wdata);
    end else if (mm_inval) begin
      if (mm_sel_u) utlb_d[mm_idx].valid = 1'b0;
      else          itlb_d[mm_idx[IW-1:0]].valid = 1'b0;
    end

    lru_d = lru_nxt;
    urc_d = urc_q;
    if (uacc) urc_d = (urc_q == UW'(U_N - 1)) ? '0 : urc_q + 1'b1;
    if (ctl_we) {lru_d, urc_d} = ctl_wdata;
  end

  // ---------------- registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < I_N; k++) itlb_q[k] <= '0;
      for (int k = 0; k < U_N; k++) utlb_q[k] <= '0;
      st_q    <= IP_IDLE;
      fvpn_q  <= '0;
      urc_q   <= '0;
      lru_q   <= '0;
      i_valid <= 1'b0;
      i_miss  <= 1'b0;
      i_multi <= 1'b0;
      ixl_q   <= '0;
      d_valid <= 1'b0;
      d_miss  <= 1'b0;
      d_multi <= 1'b0;
      dxl_q   <= '0;
    end else begin
      itlb_q  <= itlb_d;
      utlb_q  <= utlb_d;
      st_q    <= st_d;
      if (fvpn_en) fvpn_q <= i_vpn;
      urc_q   <= urc_d;
      lru_q   <= lru_d;
      i_valid <= iv_d;
      i_miss  <= imiss_d;
      i_multi <= imul_d;
      ixl_q   <= ixl_d;
      d_valid <= d_req;
      d_miss  <= d_req && !(|dm);
      d_multi <= d_req && dmul;
      if (d_req) dxl_q <= (dmul || !(|dm)) ? '0 : dxl;
    end
  end

  assign i_ready   = (st_q == IP_IDLE);
  assign {i_ppn, i_attr} = ixl_q;
  assign {d_ppn, d_attr} = dxl_q;
  assign ctl_rdata = {lru_q, urc_q};
  assign mm_rdata  = mm_sel_u ? utlb_q[mm_idx] : itlb_q[mm_idx[IW-1:0]];

  // packed view of the instruction array for the checker
  logic [I_N*ENT_W-1:0] itlb_bits;
  for (genvar k = 0; k < I_N; k++) begin : g_flat
    assign itlb_bits[k*ENT_W +: ENT_W] = itlb_q[k];
  end
endmodule

// File: rtl/xlat_twolevel_chk.sv
module xlat_twolevel_chk
  import tlb_pkg::*;
#(
  parameter  int I_N = 4,
  parameter  int U_N = 16,
  localparam int UW  = $clog2(U_N),
  localparam int LW  = I_N * (I_N - 1) / 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 i_req,
  input logic                 i_ready,
  input logic                 i_valid,
  input logic                 i_miss,
  input logic                 i_multi,
  input logic                 d_req,
  input logic                 d_valid,
  input logic                 ld_en,
  input logic                 ctl_we,
  input logic [LW+UW-1:0]     ctl_rdata,
  input logic                 mm_sel_u,
  input logic                 mm_we,
  input logic                 mm_inval,
  input logic [I_N*ENT_W-1:0] itlb_bits
);
  // R4
  fill_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !i_ready |=> (i_ready && i_valid));

  // R3
  hit_or_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (i_req && i_ready) |=> (i_valid || !i_ready));

  // R7
  fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    i_valid |-> !(i_miss && i_multi));

  // R8
  d_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    d_req |=> d_valid);

  // R12
  urc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ld_en || d_req) && !ctl_we) |=>
      (ctl_rdata[UW-1:0] == ((($past(ctl_rdata[UW-1:0])) == UW'(U_N - 1)) ?
                             UW'(0) : UW'($past(ctl_rdata[UW-1:0]) + 1'b1))));

  // R2
  itlb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (i_ready && !((mm_we || mm_inval) && !mm_sel_u)) |=> $stable(itlb_bits));
endmodule

bind xlat_twolevel xlat_twolevel_chk #(.I_N(I_N), .U_N(U_N)) u_chk (
  .clk(clk), .rst_n(rst_n), .i_req(i_req), .i_ready(i_ready),
  .i_valid(i_valid), .i_miss(i_miss), .i_multi(i_multi),
  .d_req(d_req), .d_valid(d_valid), .ld_en(ld_en), .ctl_we(ctl_we),
  .ctl_rdata(ctl_rdata), .mm_sel_u(mm_sel_u), .mm_we(mm_we),
  .mm_inval(mm_inval), .itlb_bits(itlb_bits)
);

// File: tb/xlat_twolevel_test.sv
module xlat_twolevel_test;
  localparam int CLK_NS = 10;

  logic clk = 1'b0;
  always #(CLK_NS / 2) clk = ~clk;

  logic        rst_n;
  logic [7:0]  cur_asid;
  logic        i_req, i_ready, i_valid, i_miss, i_multi;
  logic [21:0] i_vpn, d_vpn;
  logic [18:0] i_ppn, d_ppn;
  logic [5:0]  i_attr, d_attr;
  logic        d_req, d_valid, d_miss, d_multi;
  logic        ld_en;
  logic [29:0] stg_hi;
  logic [22:0] stg_lo;
  logic [3:0]  stg_as;
  logic        ctl_we;
  logic [9:0]  ctl_wdata, ctl_rdata;
  logic        mm_sel_u, mm_we, mm_inval;
  logic [3:0]  mm_idx;
  logic [56:0] mm_wdata, mm_rdata;

  xlat_twolevel uut (.*);

  int checks = 0;
  int errors = 0;
  logic [3:0] exp_urc = 4'd0;

  typedef struct {
    logic [18:0] ppn;
    logic [5:0]  attr;
    logic        miss;
    logic        multi;
    string       req;
  } exp_t;

  exp_t iq[$];
  exp_t dq[$];

  task automatic check_eq(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [56:0] mk(logic v, logic s, logic [21:0] vpn, logic [7:0] asid,
                                     logic [18:0] ppn, logic [5:0] attr);
    return {v, s, vpn, asid, ppn, attr};
  endfunction

  // monitor: pops expected results as the design presents them
  always @(negedge clk) begin
    if (rst_n) begin
      if (i_valid) begin
        if (iq.size() == 0) check_eq("R3", "unexpected instruction result", 1, 0);
        else begin
          exp_t e;
          e = iq.pop_front();
          check_eq(e.req, "instruction result {multi,miss,attr,ppn}",
                   {i_multi, i_miss, i_attr, i_ppn}, {e.multi, e.miss, e.attr, e.ppn});
        end
      end
      if (d_valid) begin
        if (dq.size() == 0) check_eq("R8", "unexpected data result", 1, 0);
        else begin
          exp_t e;
          e = dq.pop_front();
          check_eq(e.req, "data result {multi,miss,attr,ppn}",
                   {d_multi, d_miss, d_attr, d_ppn}, {e.multi, e.miss, e.attr, e.ppn});
        end
      end
    end
  end

  task automatic ilook(logic [21:0] vpn, logic [56:0] ent, logic miss, logic multi,
                       int lat, string req);
    exp_t e;
    e.ppn   = (miss || multi) ? '0 : ent[24:6];
    e.attr  = (miss || multi) ? '0 : ent[5:0];
    e.miss  = miss;
    e.multi = multi;
    e.req   = req;
    @(negedge clk);
    i_vpn = vpn;
    i_req = 1'b1;
    iq.push_back(e);
    @(negedge clk);
    i_req = 1'b0;
    check_eq(req, "i_ready after request", i_ready, (lat == 1));
    if (lat == 2) exp_urc = exp_urc + 1'b1;
    while (!i_ready) @(negedge clk);
  endtask

  task automatic dlook(logic [21:0] vpn, logic [56:0] ent, logic miss, logic multi, string req);
    exp_t e;
    e.ppn   = (miss || multi) ? '0 : ent[24:6];
    e.attr  = (miss || multi) ? '0 : ent[5:0];
    e.miss  = miss;
    e.multi = multi;
    e.req   = req;
    @(negedge clk);
    d_vpn = vpn;
    d_req = 1'b1;
    dq.push_back(e);
    @(negedge clk);
    d_req = 1'b0;
    exp_urc = exp_urc + 1'b1;
  endtask

  task automatic load(logic [56:0] ent);
    @(negedge clk);
    stg_hi = ent[54:25];
    stg_lo = {ent[56], ent[55], ent[24:6], ent[5], ent[4]};
    stg_as = ent[3:0];
    ld_en  = 1'b1;
    @(negedge clk);
    ld_en  = 1'b0;
    exp_urc = exp_urc + 1'b1;
  endtask

  task automatic ctlw(logic [9:0] v);
    @(negedge clk);
    ctl_we    = 1'b1;
    ctl_wdata = v;
    @(negedge clk);
    ctl_we  = 1'b0;
    exp_urc = v[3:0];
  endtask

  task automatic mmw(logic sel, logic [3:0] idx, logic [56:0] data);
    @(negedge clk);
    mm_sel_u = sel;
    mm_idx   = idx;
    mm_wdata = data;
    mm_we    = 1'b1;
    @(negedge clk);
    mm_we = 1'b0;
  endtask

  task automatic mminv(logic sel, logic [3:0] idx);
    @(negedge clk);
    mm_sel_u = sel;
    mm_idx   = idx;
    mm_inval = 1'b1;
    @(negedge clk);
    mm_inval = 1'b0;
  endtask

  task automatic mmrd(logic sel, logic [3:0] idx, output logic [56:0] data);
    @(negedge clk);
    mm_sel_u = sel;
    mm_idx   = idx;
    #1;
    data = mm_rdata;
  endtask

  task automatic chk_ctl(string req, logic [5:0] lru);
    check_eq("R12", "replace counter", ctl_rdata[3:0], exp_urc);
    check_eq(req, "lru field", ctl_rdata[9:4], lru);
  endtask

  initial begin
    #(CLK_NS * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [56:0] rd;
    logic [56:0] ea, eb, ec, ed, ee, purge, ef, em, e8, ew;
    ea    = mk(1, 0, 22'h1000, 8'd5, 19'h111, 6'b100111);
    eb    = mk(1, 1, 22'h2000, 8'd9, 19'h222, 6'b010000);
    ec    = mk(1, 0, 22'h3000, 8'd5, 19'h333, 6'b100000);
    ed    = mk(1, 0, 22'h4000, 8'd5, 19'h444, 6'b011010);
    ee    = mk(1, 0, 22'h5000, 8'd5, 19'h555, 6'b000001);
    purge = mk(0, 0, 22'h1000, 8'd5, 19'h0,   6'b000000);
    ef    = mk(1, 0, 22'h6000, 8'd7, 19'h666, 6'b000000);
    em    = mk(1, 0, 22'h7000, 8'd5, 19'h777, 6'b000000);
    e8    = mk(1, 0, 22'h8000, 8'd5, 19'h088, 6'b000000);
    ew    = mk(1, 0, 22'h3F0000, 8'd5, 19'h7ABCD, 6'b111111);

    rst_n = 1'b0; cur_asid = 8'd5;
    i_req = 0; i_vpn = '0; d_req = 0; d_vpn = '0;
    ld_en = 0; stg_hi = '0; stg_lo = '0; stg_as = '0;
    ctl_we = 0; ctl_wdata = '0;
    mm_sel_u = 0; mm_idx = '0; mm_we = 0; mm_inval = 0; mm_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    @(negedge clk);
    check_eq("R11", "ctl after reset", ctl_rdata, 10'd0);
    check_eq("R11", "i_ready after reset", i_ready, 1);
    check_eq("R11", "strobes after reset", {i_valid, d_valid}, 2'b00);
    mmrd(1, 4'd0, rd);
    check_eq("R11", "unified entry 0 after reset", rd, 57'd0);
    mmrd(0, 4'd0, rd);
    check_eq("R11", "instruction entry 0 after reset", rd, 57'd0);

    // R1 load-entry fills unified entries in counter order
    load(ea);
    mmrd(1, 4'd0, rd);
    check_eq("R1", "unified entry 0 after load", rd, ea);
    check_eq("R12", "counter after one load", ctl_rdata[3:0], 4'd1);
    load(eb); load(ec); load(ed); load(ee);
    chk_ctl("R11", 6'h00);

    // R4 R5 refills walk the victim order
    ilook(22'h1000, ea, 0, 0, 2, "R4");
    mmrd(0, 4'd0, rd);
    check_eq("R4", "refilled instruction slot 0", rd, ea);
    chk_ctl("R5", 6'h07);
    ilook(22'h2000, eb, 0, 0, 2, "R10");   // shared entry, foreign asid
    chk_ctl("R5", 6'h1E);
    ilook(22'h1000, ea, 0, 0, 1, "R3");    // instruction hit
    chk_ctl("R5", 6'h1F);
    ilook(22'h3000, ec, 0, 0, 2, "R5");
    chk_ctl("R5", 6'h35);
    ilook(22'h4000, ed, 0, 0, 2, "R5");
    chk_ctl("R5", 6'h01);
    ilook(22'h5000, ee, 0, 0, 2, "R5");
    chk_ctl("R5", 6'h18);
    mmrd(0, 4'd1, rd);
    check_eq("R5", "victim slot 1 replaced", rd, ee);

    // R2 stale instruction translation survives a purge
    ctlw({6'h18, 4'd0});
    load(purge);
    mmrd(0, 4'd0, rd);
    check_eq("R2", "instruction slot 0 after load-entry", rd, ea);
    ilook(22'h1000, ea, 0, 0, 1, "R2");
    dlook(22'h1000, ea, 1, 0, "R6");
    chk_ctl("R5", 6'h1F);

    // R10 asid mismatch on a private entry
    load(ef);
    ilook(22'h6000, ef, 1, 0, 2, "R10");
    check_eq("R12", "counter after refill miss", ctl_rdata[3:0], exp_urc);

    // R7 multiple hits in each array
    mmw(1, 4'd5, em);
    mmw(1, 4'd6, em);
    dlook(22'h7000, em, 0, 1, "R7");
    ilook(22'h7000, em, 0, 1, 2, "R7");
    mmw(0, 4'd2, e8);
    mmw(0, 4'd3, e8);
    ilook(22'h8000, e8, 0, 1, 1, "R7");

    // R8 data hits, including a shared entry
    dlook(22'h4000, ed, 0, 0, "R8");
    dlook(22'h2000, eb, 0, 0, "R10");

    // R9 invalidate through the port
    mminv(0, 4'd0);
    mmrd(0, 4'd0, rd);
    check_eq("R9", "invalidated entry", rd, {1'b0, ea[55:0]});
    ilook(22'h1000, ea, 1, 0, 2, "R9");

    // R12 counter wrap
    ctlw({ctl_rdata[9:4], 4'hF});
    load(ew);
    check_eq("R12", "counter wraps to zero", ctl_rdata[3:0], 4'd0);
    mmrd(1, 4'd15, rd);
    check_eq("R1", "top unified entry", rd, ew);
    dlook(22'h3F0000, ew, 0, 0, "R8");
    check_eq("R12", "counter after data lookup", ctl_rdata[3:0], exp_urc);

    repeat (3) @(negedge clk);
    check_eq("R3", "pending instruction results", iq.size(), 0);
    check_eq("R8", "pending data results", dq.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule